// File: doc/BRIEF.md
# Translation Accessed/Dirty Bit Handler

This block follows the page-table walker of an I/O address translation unit. For each leaf entry it receives, it looks at the accessed (A) and dirty (D) bits together with the access type (read or write), the translation stage (first or second), a global capability for hardware A/D updating, and the per-device update enables for each stage. It then chooses one of three outcomes:

- let the access proceed untouched;
- set the missing bits in memory with one atomic compare-and-swap;
- raise a translation fault.

A fault is final. A faulting write is dropped before it reaches memory. A faulting read gets an error completion. In both cases a fault record goes to the driver side.

The control is a four-state machine:

- **IDLE** takes a request and moves to **REPORT** when no write-back is needed, or to **ISSUE** when one is.
- **ISSUE** holds the compare-and-swap request on the memory port until it is accepted, then moves to **WAIT**.
- **WAIT** holds until the memory response arrives, then moves to **REPORT**.
- **REPORT** presents the result for one cycle and returns to **IDLE**.

Only one request is handled at a time. The input-ready signal is high only in IDLE.

Top module: `ad_bit_handler`

## Requirements
- R1: When `cap_hw_ad` is 0 at acceptance, the block never issues a memory request, and any entry that needs a bit set produces a fault.
- R2: A first-stage request (`req_stage`=0) is governed by `en_first_ad`, and a second-stage request (`req_stage`=1) by `en_second_ad`. Updating happens only when the capability and the selected enable are both 1.
- R3: The swap value written never clears a bit. Every bit set in the compare value is set in the swap value, and only A (bit 6) and D (bit 7) may go from 0 to 1.
- R4: When updating is enabled, a write to an entry with A=1 and D=0 issues one compare-and-swap that sets D. On a compare match it completes with status OK (0) and returns the updated entry.
- R5: When updating is enabled, any access to an entry with A=0 sets A. A write with A=0 and D=0 sets both bits in a single memory request.
- R6: A write that needs a bit set while updating is disabled completes with status FAULT (1). It raises `rsp_wr_drop`, not `rsp_dev_err`, issues no memory request, and gives fault cause WRITE (2).
- R7: A read that needs A set while updating is disabled completes with status FAULT (1). It raises `rsp_dev_err` and gives fault cause READ (1).
- R8: If the value returned by memory differs from the compare value, the block completes with status RESTART (2) and returns the observed value. It never issues a second request for that transaction.
- R9: `req_ready` is low from the cycle after acceptance until the response has been presented. At most one memory request is outstanding.
- R10: An access needing no bit change (A=1, and D=1 for writes) completes with status OK, the unchanged entry, and no memory request.
- R11: The fault record (`flt_valid`, `flt_write`, `flt_stage`, `flt_cause`) pulses together with the FAULT response. It carries the access type and the stage of the faulting request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Handler can accept (IDLE) |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_stage | input | 1 | 0 = first stage, 1 = second stage |
| req_pte_addr | input | AW | Address of the leaf entry |
| req_pte | input | PW | Leaf entry value as fetched |
| cap_hw_ad | input | 1 | Global hardware A/D update capability |
| en_first_ad | input | 1 | Device enable for first-stage updates |
| en_second_ad | input | 1 | Device enable for second-stage updates |
| mem_req_valid | output | 1 | Compare-and-swap request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Entry address for the swap |
| mem_req_cmp | output | PW | Expected current value |
| mem_req_swap | output | PW | Value to store on match |
| mem_rsp_valid | input | 1 | Swap response valid |
| mem_rsp_data | input | PW | Value found in memory |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_status | output | 2 | 0 OK, 1 FAULT, 2 RESTART |
| rsp_pte | output | PW | Resulting or observed entry |
| rsp_dev_err | output | 1 | Error completion to device (read fault) |
| rsp_wr_drop | output | 1 | Write discarded (write fault) |
| flt_valid | output | 1 | Fault record valid |
| flt_write | output | 1 | Access type of the faulting request |
| flt_stage | output | 1 | Stage of the faulting request |
| flt_cause | output | 2 | 1 read fault, 2 write fault |

## Verification
Random entries are mixed with random access types, stages, capability and enable settings. This covers all four A/D combinations under both reads and writes, which separates the pass, update and fault outcomes. Directed cases do three jobs:

- They hold the capability low with both enables high, which separates R1 from R2.
- They enable one stage and send a request to the other, which tells whether the stage picks the correct enable.
- They corrupt the memory word behind the handler, which separates a successful swap from a restart.

Random memory-ready stalls exercise the hold behaviour of the request port.

// File: rtl/ad_pkg.sv
package ad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_REPORT = 2'd3
    } ad_state_e;

    typedef enum logic [1:0] {
        OC_PASS   = 2'd0,
        OC_UPDATE = 2'd1,
        OC_FAULT  = 2'd2
    } ad_outcome_e;

    localparam logic [1:0] RSP_OK      = 2'd0;
    localparam logic [1:0] RSP_FAULT   = 2'd1;
    localparam logic [1:0] RSP_RESTART = 2'd2;

    localparam logic [1:0] CAUSE_NONE  = 2'd0;
    localparam logic [1:0] CAUSE_READ  = 2'd1;
    localparam logic [1:0] CAUSE_WRITE = 2'd2;

endpackage

// File: rtl/ad_need_eval.sv
module ad_need_eval
    import ad_pkg::*;
#(
    parameter int PW    = 64,
    parameter int A_BIT = 6,
    parameter int D_BIT = 7
) (
    input  logic [PW-1:0] pte_i,
    input  logic          write_i,
    input  logic          stage_i,
    input  logic          cap_i,
    input  logic          en_first_i,
    input  logic          en_second_i,
    output logic          need_a_o,
    output logic          need_d_o,
    output ad_outcome_e   outcome_o
);

    logic stage_en;
    logic upd_ok;

    always_comb begin
        need_a_o  = ~pte_i[A_BIT];
        need_d_o  = write_i & ~pte_i[D_BIT];
        stage_en  = stage_i ? en_second_i : en_first_i;
        upd_ok    = cap_i & stage_en;
        if (!(need_a_o || need_d_o)) begin
            outcome_o = OC_PASS;
        end else if (upd_ok) begin
            outcome_o = OC_UPDATE;
        end else begin
            outcome_o = OC_FAULT;
        end
    end

endmodule

// File: rtl/ad_swap_gen.sv
module ad_swap_gen #(
    parameter int PW    = 64,
    parameter int A_BIT = 6,
    parameter int D_BIT = 7
) (
    input  logic [PW-1:0] pte_i,
    input  logic          set_a_i,
    input  logic          set_d_i,
    output logic [PW-1:0] swap_o
);

    for (genvar i = 0; i < PW; i++) begin : g_bit
        if (i == A_BIT) begin : g_a
            assign swap_o[i] = pte_i[i] | set_a_i;
        end else if (i == D_BIT) begin : g_d
            assign swap_o[i] = pte_i[i] | set_d_i;
        end else begin : g_keep
            assign swap_o[i] = pte_i[i];
        end
    end

endmodule

// File: rtl/ad_cas_check.sv
module ad_cas_check #(
    parameter int PW = 64
) (
    input  logic [PW-1:0] cmp_i,
    input  logic [PW-1:0] obs_i,
    output logic          match_o
);

    assign match_o = (cmp_i == obs_i);

endmodule

// File: rtl/ad_fault_fmt.sv
module ad_fault_fmt
    import ad_pkg::*;
(
    input  logic       fault_i,
    input  logic       write_i,
    output logic       dev_err_o,
    output logic       wr_drop_o,
    output logic [1:0] cause_o
);

    always_comb begin
        dev_err_o = fault_i & ~write_i;
        wr_drop_o = fault_i & write_i;
        if (!fault_i) begin
            cause_o = CAUSE_NONE;
        end else if (write_i) begin
            cause_o = CAUSE_WRITE;
        end else begin
            cause_o = CAUSE_READ;
        end
    end

endmodule

// File: rtl/ad_bit_handler.sv
module ad_bit_handler
    import ad_pkg::*;
#(
    parameter int PW    = 64,
    parameter int AW    = 56,
    parameter int A_BIT = 6,
    parameter int D_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_stage,
    input  logic [AW-1:0] req_pte_addr,
    input  logic [PW-1:0] req_pte,
    input  logic          cap_hw_ad,
    input  logic          en_first_ad,
    input  logic          en_second_ad,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    output logic [PW-1:0] mem_req_cmp,
    output logic [PW-1:0] mem_req_swap,
    input  logic          mem_rsp_valid,
    input  logic [PW-1:0] mem_rsp_data,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [PW-1:0] rsp_pte,
    output logic          rsp_dev_err,
    output logic          rsp_wr_drop,
    output logic          flt_valid,
    output logic          flt_write,
    output logic          flt_stage,
    output logic [1:0]    flt_cause
);

    ad_state_e   state_q, state_d;
    ad_outcome_e oc_w;
    logic        accept;
    logic        need_a_w, need_d_w;
    logic [PW-1:0] pte_q, res_pte_q, swap_w;
    logic [AW-1:0] addr_q;
    logic        wr_q, stg_q, cap_q;
    logic        set_a_q, set_d_q;
    logic [1:0]  status_q;
    logic        cas_match_w;
    logic        fault_now;

    assign accept = req_valid && (state_q == ST_IDLE);

    ad_need_eval #(.PW(PW), .A_BIT(A_BIT), .D_BIT(D_BIT)) u_eval (
        .pte_i       (req_pte),
        .write_i     (req_write),
        .stage_i     (req_stage),
        .cap_i       (cap_hw_ad),
        .en_first_i  (en_first_ad),
        .en_second_i (en_second_ad),
        .need_a_o    (need_a_w),
        .need_d_o    (need_d_w),
        .outcome_o   (oc_w)
    );

    ad_swap_gen #(.PW(PW), .A_BIT(A_BIT), .D_BIT(D_BIT)) u_swap (
        .pte_i   (pte_q),
        .set_a_i (set_a_q),
        .set_d_i (set_d_q),
        .swap_o  (swap_w)
    );

    ad_cas_check #(.PW(PW)) u_cas (
        .cmp_i   (pte_q),
        .obs_i   (mem_rsp_data),
        .match_o (cas_match_w)
    );

    ad_fault_fmt u_flt (
        .fault_i   (fault_now),
        .write_i   (wr_q),
        .dev_err_o (rsp_dev_err),
        .wr_drop_o (rsp_wr_drop),
        .cause_o   (flt_cause)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (oc_w == OC_UPDATE) ? ST_ISSUE : ST_REPORT;
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = ST_REPORT;
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Transaction context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pte_q     <= '0;
            res_pte_q <= '0;
            addr_q    <= '0;
            wr_q      <= 1'b0;
            stg_q     <= 1'b0;
            cap_q     <= 1'b0;
            set_a_q   <= 1'b0;
            set_d_q   <= 1'b0;
            status_q  <= RSP_OK;
        end else begin
            if (accept) begin
                pte_q     <= req_pte;
                res_pte_q <= req_pte;
                addr_q    <= req_pte_addr;
                wr_q      <= req_write;
                stg_q     <= req_stage;
                cap_q     <= cap_hw_ad;
                set_a_q   <= need_a_w && (oc_w == OC_UPDATE);
                set_d_q   <= need_d_w && (oc_w == OC_UPDATE);
                status_q  <= (oc_w == OC_FAULT) ? RSP_FAULT : RSP_OK;
            end else if ((state_q == ST_WAIT) && mem_rsp_valid) begin
                status_q  <= cas_match_w ? RSP_OK : RSP_RESTART;
                res_pte_q <= cas_match_w ? swap_w : mem_rsp_data;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        rsp_valid     = 1'b0;
        fault_now     = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready     = 1'b1;
            ST_ISSUE:  mem_req_valid = 1'b1;
            ST_WAIT:   ;
            ST_REPORT: begin
                rsp_valid = 1'b1;
                fault_now = (status_q == RSP_FAULT);
            end
        endcase
        flt_valid    = fault_now;
        flt_write    = wr_q;
        flt_stage    = stg_q;
        rsp_status   = status_q;
        rsp_pte      = res_pte_q;
        mem_req_addr = addr_q;
        mem_req_cmp  = pte_q;
        mem_req_swap = swap_w;
    end

endmodule

// File: rtl/ad_bit_handler_chk.sv
module ad_bit_handler_chk
    import ad_pkg::*;
#(
    parameter int PW = 64,
    parameter int AW = 56
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [PW-1:0] mem_req_cmp,
    input logic [PW-1:0] mem_req_swap,
    input logic          mem_rsp_valid,
    input logic [PW-1:0] mem_rsp_data,
    input logic          rsp_valid,
    input logic [1:0]    rsp_status,
    input logic          rsp_dev_err,
    input logic          rsp_wr_drop,
    input logic          flt_valid,
    input logic          flt_write,
    input logic [1:0]    flt_cause,
    input logic          cap_latched,
    input logic          waiting
);

    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_req_swap & mem_req_cmp) == mem_req_cmp));

    assert_cap_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> cap_latched);

    assert_write_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_write) |-> (rsp_wr_drop && !rsp_dev_err && flt_cause == CAUSE_WRITE));

    assert_read_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_write) |-> (rsp_dev_err && !rsp_wr_drop && flt_cause == CAUSE_READ));

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && mem_rsp_valid && (mem_rsp_data != mem_req_cmp))
            |=> (rsp_valid && rsp_status == RSP_RESTART && !mem_req_valid));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_swap)));

    assert_fault_record_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (rsp_valid && rsp_status == RSP_FAULT));

endmodule

bind ad_bit_handler ad_bit_handler_chk #(.PW(PW), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_cmp   (mem_req_cmp),
    .mem_req_swap  (mem_req_swap),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .rsp_dev_err   (rsp_dev_err),
    .rsp_wr_drop   (rsp_wr_drop),
    .flt_valid     (flt_valid),
    .flt_write     (flt_write),
    .flt_cause     (flt_cause),
    .cap_latched   (cap_q),
    .waiting       (state_q == ad_pkg::ST_WAIT)
);

// File: tb/ad_bit_handler_tb_top.sv
module ad_bit_handler_tb_top;

    localparam int PW = 64;
    localparam int AW = 56;
    localparam int AB = 6;
    localparam int DB = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_stage = 1'b0;
    logic [AW-1:0] req_pte_addr = '0;
    logic [PW-1:0] req_pte = '0;
    logic          cap_hw_ad = 1'b0;
    logic          en_first_ad = 1'b0;
    logic          en_second_ad = 1'b0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [PW-1:0] mem_req_cmp;
    logic [PW-1:0] mem_req_swap;
    logic          mem_rsp_valid = 1'b0;
    logic [PW-1:0] mem_rsp_data = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [PW-1:0] rsp_pte;
    logic          rsp_dev_err;
    logic          rsp_wr_drop;
    logic          flt_valid;
    logic          flt_write;
    logic          flt_stage;
    logic [1:0]    flt_cause;

    int errors = 0;
    int checks = 0;
    int mem_reqs = 0;
    logic [PW-1:0] mem_word = '0;
    logic [PW-1:0] last_swap = '0;
    logic          done = 1'b0;

    always #4 clk = ~clk;

    ad_bit_handler #(.PW(PW), .AW(AW), .A_BIT(AB), .D_BIT(DB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_stage(req_stage), .req_pte_addr(req_pte_addr),
        .req_pte(req_pte), .cap_hw_ad(cap_hw_ad), .en_first_ad(en_first_ad),
        .en_second_ad(en_second_ad), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_cmp(mem_req_cmp), .mem_req_swap(mem_req_swap),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pte(rsp_pte),
        .rsp_dev_err(rsp_dev_err), .rsp_wr_drop(rsp_wr_drop), .flt_valid(flt_valid),
        .flt_write(flt_write), .flt_stage(flt_stage), .flt_cause(flt_cause)
    );

    task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 pass, 1 update, 2 fault
    function automatic int exp_outcome(logic [PW-1:0] p, logic wr, logic stg,
                                       logic cap, logic e1, logic e2);
        logic need;
        logic en;
        need = !p[AB] || (wr && !p[DB]);
        en   = cap && (stg ? e2 : e1);
        if (!need) return 0;
        return en ? 1 : 2;
    endfunction

    function automatic logic [PW-1:0] exp_swap(logic [PW-1:0] p, logic wr);
        logic [PW-1:0] s;
        s = p;
        s[AB] = 1'b1;
        if (wr) s[DB] = 1'b1;
        return s;
    endfunction

    // Memory model: one compare-and-swap per accepted request
    initial begin
        bit pend;
        pend = 1'b0;
        forever begin
            @(negedge clk);
            if (pend) begin
                mem_reqs++;
                last_swap     = mem_req_swap;
                mem_rsp_data  = mem_word;
                if (mem_word == mem_req_cmp) mem_word = mem_req_swap;
                mem_rsp_valid = 1'b1;
                mem_req_ready = 1'b0;
                pend = 1'b0;
            end else begin
                mem_rsp_valid = 1'b0;
                mem_req_ready = ($urandom % 3) != 0;
                pend = mem_req_valid && mem_req_ready;
            end
        end
    end

    task automatic run_one(input logic [PW-1:0] p, input logic wr, input logic stg,
                           input logic cap, input logic e1, input logic e2,
                           input bit race, input string tag);
        int oc;
        int base;
        bit got;
        bit busy_ok;
        logic [PW-1:0] stored;
        oc = exp_outcome(p, wr, stg, cap, e1, e2);
        stored = race ? (p ^ 64'h0000_0100_0000_0000) : p;
        @(negedge clk);
        mem_word     = stored;
        base         = mem_reqs;
        req_pte      = p;
        req_write    = wr;
        req_stage    = stg;
        cap_hw_ad    = cap;
        en_first_ad  = e1;
        en_second_ad = e2;
        req_pte_addr = {$urandom, $urandom} & {AW{1'b1}};
        req_valid    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got = 1'b0;
        busy_ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (rsp_valid) begin
                got = 1'b1;
                break;
            end
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        chk(got, {"R9 response arrives ", tag}, 64'(got), 64'd1);
        if (!got) return;
        chk(busy_ok, {"R9 ready low while busy ", tag}, 64'(busy_ok), 64'd1);
        if (oc == 0) begin
            chk(rsp_status == 2'd0, {"R10 status ", tag}, 64'(rsp_status), 64'd0);
            chk(rsp_pte == p, {"R10 pte unchanged ", tag}, rsp_pte, p);
            chk(mem_reqs == base, {"R10 no mem req ", tag}, 64'(mem_reqs - base), 64'd0);
            chk(!flt_valid, {"R10 no fault ", tag}, 64'(flt_valid), 64'd0);
        end else if (oc == 1) begin
            chk(mem_reqs == base + 1, {"R5 single mem req ", tag}, 64'(mem_reqs - base), 64'd1);
            chk(last_swap == exp_swap(p, wr), {"R3 R4 swap value ", tag}, last_swap, exp_swap(p, wr));
            chk(!flt_valid, {"R4 no fault ", tag}, 64'(flt_valid), 64'd0);
            if (race) begin
                chk(rsp_status == 2'd2, {"R8 restart status ", tag}, 64'(rsp_status), 64'd2);
                chk(rsp_pte == stored, {"R8 observed pte ", tag}, rsp_pte, stored);
            end else begin
                chk(rsp_status == 2'd0, {"R4 ok status ", tag}, 64'(rsp_status), 64'd0);
                chk(rsp_pte == exp_swap(p, wr), {"R5 updated pte ", tag}, rsp_pte, exp_swap(p, wr));
            end
        end else begin
            chk(rsp_status == 2'd1, {"R1 fault status ", tag}, 64'(rsp_status), 64'd1);
            chk(mem_reqs == base, {"R6 no mem req ", tag}, 64'(mem_reqs - base), 64'd0);
            chk(flt_valid && flt_write == wr && flt_stage == stg,
                {"R11 fault record ", tag}, {61'd0, flt_valid, flt_write, flt_stage},
                {61'd0, 1'b1, wr, stg});
            if (wr) begin
                chk(rsp_wr_drop && !rsp_dev_err && flt_cause == 2'd2, {"R6 write fault ", tag},
                    {61'd0, rsp_wr_drop, flt_cause}, {61'd0, 1'b1, 2'd2});
            end else begin
                chk(rsp_dev_err && !rsp_wr_drop && flt_cause == 2'd1, {"R7 read fault ", tag},
                    {61'd0, rsp_dev_err, flt_cause}, {61'd0, 1'b1, 2'd1});
            end
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, {"R9 back to idle ", tag}, 64'(rsp_valid), 64'd0);
        chk(mem_reqs == base + (oc == 1 ? 1 : 0), {"R8 no retry ", tag},
            64'(mem_reqs - base), 64'(oc == 1 ? 1 : 0));
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid && !flt_valid, "R9 reset state",
            {60'd0, req_ready, rsp_valid, mem_req_valid, flt_valid}, 64'h8);

        // Directed corner cases (A bit 6, D bit 7)
        run_one(64'h00C0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R10 write A1 D1");
        run_one(64'h0040, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 write D0 first");
        run_one(64'h1000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5 write A0 D0 second");
        run_one(64'h1000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 read A0");
        run_one(64'h0040, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R1 cap off write");
        run_one(64'h0080, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R1 cap off read");
        run_one(64'h0040, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2 second disabled");
        run_one(64'h0040, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R2 first disabled");
        run_one(64'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 read fault");
        run_one(64'h0040, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R8 compare mismatch");
        run_one(64'h00C0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 read A1");

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [PW-1:0] p;
            p = {$urandom, $urandom};
            run_one(p, 1'($urandom), 1'($urandom), ($urandom % 4) != 0,
                    1'($urandom), 1'($urandom), ($urandom % 6) == 0, "random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule